// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch condition of every hardware thread in a multithreaded front end. Each thread holds a small state machine, a redirect program counter pair and four sticky stall flags, one for each downstream stage (decode, rename, execute, commit). Each cycle the block folds in squash requests, stall pulses, instruction-cache miss issues and cache responses, and gives each thread's state one cycle later.

Events are resolved in a fixed priority order. A commit squash comes first, then a reorder-buffer squash hold, then a decode squash, then a stall, then recovery to running. Cache responses carry a tag. A response is accepted only while the thread still waits on that exact tag, so a response that a squash left behind is discarded. The block also raises a stage-active flag that lets the pipeline clock-gate or skip the fetch stage when no enabled thread can make progress.

Top module: `fetch_thread_ctrl`

## Requirements
- R1: Each thread has four sticky stall flags. Flag s of thread t is set by `stall_set[t*4+s]` and cleared by `stall_clr[t*4+s]`, with s=0 decode, 1 rename, 2 execute, 3 commit. A flag keeps its value between pulses.
- R2: State codes are RUN=0, IDLE=1, SQUASH=2, BLOCKED=3, WAIT_MEM=4, MEM_DONE=5, TRAP_WAIT=6, QUIESCE_WAIT=7. A commit squash beats every other event. One cycle after it, `pc` equals the target, `next_pc` equals target+INST_BYTES and the state is SQUASH.
- R3: A commit or decode squash taken while the thread is in WAIT_MEM abandons the outstanding request. A later response carrying the old tag is ignored.
- R4: If there is no commit squash, a set `rob_squashing` bit puts or holds the thread in SQUASH.
- R5: A decode squash is handled only when neither commit input applies. It redirects `pc`/`next_pc` only when the thread is not already in SQUASH. When the thread is in SQUASH, the PCs are unchanged and evaluation continues with the stall and recovery rules.
- R6: If any updated stall flag or `ctx_switch` is set and the thread is not in WAIT_MEM, the thread goes to BLOCKED. A thread in WAIT_MEM stays there.
- R7: In a cycle with no squash and no stall, a thread in BLOCKED or SQUASH returns to RUN.
- R8: A `miss_issue` pulse on a thread in RUN that has no higher-priority event moves it to WAIT_MEM and records `miss_tag` as its outstanding tag.
- R9: A response (`resp_valid`, `resp_tid`, `resp_tag`) is ignored unless the named thread is in WAIT_MEM and the tag matches its outstanding tag.
- R10: An accepted response moves the thread to BLOCKED if a stall is pending, and otherwise to MEM_DONE. MEM_DONE becomes RUN on the next cycle when there is no other event.
- R11: `stage_active` is registered. After each edge it is 1 when some thread whose `thread_active` bit was set is in RUN, SQUASH or MEM_DONE, and 0 otherwise. It is 0 in reset.
- R12: A block and an unblock pulse for the same flag in the same cycle raise `proto_err[t]` for one cycle. In that case the set wins.
- R13: Synchronous reset puts every thread in RUN with `pc`=RESET_PC, `next_pc`=RESET_PC+INST_BYTES, all stall flags clear and no tag outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active | input | NUM_THREADS | Threads that count toward stage activity |
| stall_set | input | 4*NUM_THREADS | Block pulses, bit t*4+s |
| stall_clr | input | 4*NUM_THREADS | Unblock pulses, bit t*4+s |
| ctx_switch | input | 1 | Global context-switch stall |
| cmt_squash | input | NUM_THREADS | Commit squash per thread |
| cmt_target | input | NUM_THREADS*PC_W | Commit redirect target, thread t at [t*PC_W +: PC_W] |
| rob_squashing | input | NUM_THREADS | Reorder buffer still squashing |
| dec_squash | input | NUM_THREADS | Decode squash per thread |
| dec_target | input | NUM_THREADS*PC_W | Decode redirect target |
| miss_issue | input | NUM_THREADS | Cache request issued by thread |
| miss_tag | input | NUM_THREADS*TAG_W | Tag of the issued request |
| resp_valid | input | 1 | Cache response valid |
| resp_tid | input | TID_W | Thread of the response |
| resp_tag | input | TAG_W | Tag of the response |
| thr_state | output | NUM_THREADS*3 | State code per thread |
| pc | output | NUM_THREADS*PC_W | Current fetch PC per thread |
| next_pc | output | NUM_THREADS*PC_W | Next PC per thread |
| stage_active | output | 1 | Fetch stage has useful work |
| proto_err | output | NUM_THREADS | Same-cycle block/unblock conflict |

## Verification
The bench builds the block with two threads, 16-bit PCs and 3-bit tags. Two threads are enough to show that one thread's pulses leave the other alone, that a response naming the wrong thread is dropped, and that `stage_active` ignores a thread whose enable bit is clear. The narrow tag lets a stale tag and a fresh tag coexist in a short run, so the abandoned-request case is reachable.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int STAGES = 4;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQUASH   = 3'd2,
    ST_BLOCKED  = 3'd3,
    ST_WAIT_MEM = 3'd4,
    ST_MEM_DONE = 3'd5,
    ST_TRAP     = 3'd6,
    ST_QUIESCE  = 3'd7
  } fstate_e;

  function automatic logic is_busy(fstate_e s);
    return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_MEM_DONE);
  endfunction
endpackage

// File: rtl/ftc_stall_bits.sv
module ftc_stall_bits #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  output logic [NS-1:0] bits_q,
  output logic [NS-1:0] bits_nxt,
  output logic          err_q
);
  always_comb begin
    bits_nxt = (bits_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      err_q  <= 1'b0;
    end else begin
      bits_q <= bits_nxt;
      err_q  <= |(set_i & clr_i);
    end
  end
endmodule

// File: rtl/ftc_thread_fsm.sv
module ftc_thread_fsm
  import ftc_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          TAG_W      = 4,
  parameter int          INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_any,
  input  logic             cmt_sq,
  input  logic [PC_W-1:0]  cmt_tgt,
  input  logic             rob_sq,
  input  logic             dec_sq,
  input  logic [PC_W-1:0]  dec_tgt,
  input  logic             issue,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             resp_hit,
  input  logic [TAG_W-1:0] resp_tag,
  output fstate_e          state_q,
  output fstate_e          state_nxt,
  output logic [PC_W-1:0]  pc_q,
  output logic [PC_W-1:0]  npc_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  logic [TAG_W-1:0] tag_q, tag_nxt;
  logic             tag_vld_q, tag_vld_nxt;
  logic [PC_W-1:0]  pc_nxt, npc_nxt;
  logic             accept;

  assign accept = (state_q == ST_WAIT_MEM) && resp_hit && tag_vld_q && (resp_tag == tag_q);

  always_comb begin
    state_nxt   = state_q;
    pc_nxt      = pc_q;
    npc_nxt     = npc_q;
    tag_nxt     = tag_q;
    tag_vld_nxt = tag_vld_q;
    if (cmt_sq) begin
      pc_nxt      = cmt_tgt;
      npc_nxt     = cmt_tgt + STEP;
      state_nxt   = ST_SQUASH;
      tag_vld_nxt = 1'b0;
    end else if (rob_sq) begin
      state_nxt   = ST_SQUASH;
      tag_vld_nxt = 1'b0;
    end else if (dec_sq && state_q != ST_SQUASH) begin
      pc_nxt      = dec_tgt;
      npc_nxt     = dec_tgt + STEP;
      state_nxt   = ST_SQUASH;
      tag_vld_nxt = 1'b0;
    end else if (stall_any && state_q != ST_WAIT_MEM) begin
      state_nxt = ST_BLOCKED;
    end else if (state_q == ST_BLOCKED || state_q == ST_SQUASH) begin
      state_nxt = ST_RUN;
    end else if (state_q == ST_MEM_DONE) begin
      state_nxt = ST_RUN;
    end else if (accept) begin
      state_nxt   = stall_any ? ST_BLOCKED : ST_MEM_DONE;
      tag_vld_nxt = 1'b0;
    end else if (state_q == ST_RUN && issue) begin
      state_nxt   = ST_WAIT_MEM;
      tag_nxt     = issue_tag;
      tag_vld_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      pc_q      <= RESET_PC;
      npc_q     <= RESET_PC + STEP;
      tag_q     <= '0;
      tag_vld_q <= 1'b0;
    end else begin
      state_q   <= state_nxt;
      pc_q      <= pc_nxt;
      npc_q     <= npc_nxt;
      tag_q     <= tag_nxt;
      tag_vld_q <= tag_vld_nxt;
    end
  end
endmodule

// File: rtl/ftc_activity.sv
module ftc_activity #(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] enable_i,
  input  logic [NT-1:0] busy_nxt,
  output logic          active_q
);
  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= |(enable_i & busy_nxt);
  end
endmodule

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl
  import ftc_pkg::*;
#(
  parameter int          NUM_THREADS = 2,
  parameter int          PC_W        = 32,
  parameter int          TAG_W       = 4,
  parameter int          INST_BYTES  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int         TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_THREADS-1:0]       thread_active,
  input  logic [NUM_THREADS*4-1:0]     stall_set,
  input  logic [NUM_THREADS*4-1:0]     stall_clr,
  input  logic                         ctx_switch,
  input  logic [NUM_THREADS-1:0]       cmt_squash,
  input  logic [NUM_THREADS*PC_W-1:0]  cmt_target,
  input  logic [NUM_THREADS-1:0]       rob_squashing,
  input  logic [NUM_THREADS-1:0]       dec_squash,
  input  logic [NUM_THREADS*PC_W-1:0]  dec_target,
  input  logic [NUM_THREADS-1:0]       miss_issue,
  input  logic [NUM_THREADS*TAG_W-1:0] miss_tag,
  input  logic                         resp_valid,
  input  logic [TID_W-1:0]             resp_tid,
  input  logic [TAG_W-1:0]             resp_tag,
  output logic [NUM_THREADS*3-1:0]     thr_state,
  output logic [NUM_THREADS*PC_W-1:0]  pc,
  output logic [NUM_THREADS*PC_W-1:0]  next_pc,
  output logic                         stage_active,
  output logic [NUM_THREADS-1:0]       proto_err
);
  logic [NUM_THREADS*4-1:0] stall_q;
  logic [NUM_THREADS*4-1:0] stall_nxt;
  logic [NUM_THREADS-1:0]   busy_nxt;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fstate_e st_q, st_nxt;
    logic    hit;

    assign hit = resp_valid && (resp_tid == TID_W'(t));

    ftc_stall_bits #(.NS(STAGES)) u_stall (
      .clk      (clk),
      .rst      (rst),
      .set_i    (stall_set[t*4 +: 4]),
      .clr_i    (stall_clr[t*4 +: 4]),
      .bits_q   (stall_q[t*4 +: 4]),
      .bits_nxt (stall_nxt[t*4 +: 4]),
      .err_q    (proto_err[t])
    );

    ftc_thread_fsm #(
      .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
    ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .stall_any ((|stall_nxt[t*4 +: 4]) | ctx_switch),
      .cmt_sq    (cmt_squash[t]),
      .cmt_tgt   (cmt_target[t*PC_W +: PC_W]),
      .rob_sq    (rob_squashing[t]),
      .dec_sq    (dec_squash[t]),
      .dec_tgt   (dec_target[t*PC_W +: PC_W]),
      .issue     (miss_issue[t]),
      .issue_tag (miss_tag[t*TAG_W +: TAG_W]),
      .resp_hit  (hit),
      .resp_tag  (resp_tag),
      .state_q   (st_q),
      .state_nxt (st_nxt),
      .pc_q      (pc[t*PC_W +: PC_W]),
      .npc_q     (next_pc[t*PC_W +: PC_W])
    );

    assign thr_state[t*3 +: 3] = st_q;
    assign busy_nxt[t]         = is_busy(st_nxt);
  end

  ftc_activity #(.NT(NUM_THREADS)) u_act (
    .clk      (clk),
    .rst      (rst),
    .enable_i (thread_active),
    .busy_nxt (busy_nxt),
    .active_q (stage_active)
  );
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int NT    = 2,
  parameter int PC_W  = 32,
  parameter int TAG_W = 4,
  parameter int TID_W = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NT*4-1:0]      stall_set,
  input logic [NT*4-1:0]      stall_clr,
  input logic [NT*4-1:0]      stall_q,
  input logic [NT-1:0]        cmt_squash,
  input logic [NT*PC_W-1:0]   cmt_target,
  input logic [NT-1:0]        rob_squashing,
  input logic [NT-1:0]        dec_squash,
  input logic                 resp_valid,
  input logic [TID_W-1:0]     resp_tid,
  input logic [NT*3-1:0]      thr_state,
  input logic [NT*PC_W-1:0]   pc,
  input logic [NT-1:0]        proto_err
);
  for (genvar i = 0; i < NT*4; i++) begin : g_bit
    AST_STALL_SET_STICKY: assert property (@(posedge clk) disable iff (rst)
      stall_set[i] |=> stall_q[i]);  // R1
    AST_STALL_CLR: assert property (@(posedge clk) disable iff (rst)
      (stall_clr[i] && !stall_set[i]) |=> !stall_q[i]);  // R1
  end

  for (genvar t = 0; t < NT; t++) begin : g_t
    AST_CMT_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      cmt_squash[t] |=> (thr_state[t*3 +: 3] == 3'd2) &&
                        (pc[t*PC_W +: PC_W] == $past(cmt_target[t*PC_W +: PC_W])));  // R2
    AST_ROB_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rob_squashing[t] && !cmt_squash[t]) |=> thr_state[t*3 +: 3] == 3'd2);  // R4
    AST_DEC_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      (dec_squash[t] && !cmt_squash[t] && !rob_squashing[t] && thr_state[t*3 +: 3] == 3'd2)
        |=> $stable(pc[t*PC_W +: PC_W]));  // R5
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (thr_state[t*3 +: 3] == 3'd4 && !cmt_squash[t] && !rob_squashing[t] && !dec_squash[t] &&
       !(resp_valid && resp_tid == TID_W'(t))) |=> thr_state[t*3 +: 3] == 3'd4);  // R9
    AST_PROTO_ERR: assert property (@(posedge clk) disable iff (rst)
      (|(stall_set[t*4 +: 4] & stall_clr[t*4 +: 4])) |=> proto_err[t]);  // R12
  end
endmodule

bind fetch_thread_ctrl ftc_checker #(
  .NT(NUM_THREADS), .PC_W(PC_W), .TAG_W(TAG_W), .TID_W(TID_W)
) u_ftc_chk (
  .clk(clk), .rst(rst), .stall_set(stall_set), .stall_clr(stall_clr),
  .stall_q(stall_q), .cmt_squash(cmt_squash), .cmt_target(cmt_target),
  .rob_squashing(rob_squashing), .dec_squash(dec_squash),
  .resp_valid(resp_valid), .resp_tid(resp_tid), .thr_state(thr_state),
  .pc(pc), .proto_err(proto_err)
);

// File: tb/tb_fetch_thread_ctrl.sv
module tb_fetch_thread_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int PW = 16;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0]    thread_active;
  logic [NT*4-1:0]  stall_set, stall_clr;
  logic             ctx_switch;
  logic [NT-1:0]    cmt_squash, rob_squashing, dec_squash, miss_issue;
  logic [NT*PW-1:0] cmt_target, dec_target;
  logic [NT*TW-1:0] miss_tag;
  logic             resp_valid;
  logic [0:0]       resp_tid;
  logic [TW-1:0]    resp_tag;
  logic [NT*3-1:0]  thr_state;
  logic [NT*PW-1:0] pc, next_pc;
  logic             stage_active;
  logic [NT-1:0]    proto_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_thread_ctrl #(
    .NUM_THREADS(NT), .PC_W(PW), .TAG_W(TW), .INST_BYTES(4), .RESET_PC(16'h0100)
  ) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    stall_set = '0; stall_clr = '0; ctx_switch = 0;
    cmt_squash = '0; rob_squashing = '0; dec_squash = '0;
    miss_issue = '0; resp_valid = 0; resp_tid = '0; resp_tag = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int st(int t);
    return int'(thr_state[t*3 +: 3]);
  endfunction

  task automatic t_reset();
    idle(); thread_active = 2'b11; cmt_target = '0; dec_target = '0; miss_tag = '0;
    rst = 1; tick(); tick();
    chk("R13 state t0", st(0), 0);
    chk("R13 state t1", st(1), 0);
    chk("R13 pc", int'(pc[15:0]), 'h100);
    chk("R13 next_pc", int'(next_pc[15:0]), 'h104);
    chk("R11 active in reset", int'(stage_active), 0);
    rst = 0; tick();
    chk("R11 active after reset", int'(stage_active), 1);
  endtask

  task automatic t_commit();
    cmt_squash = 2'b01; cmt_target[15:0] = 16'h2000;
    dec_squash = 2'b01; dec_target[15:0] = 16'h5000;
    tick(); idle();
    chk("R2 state", st(0), 2);
    chk("R2 pc beats decode", int'(pc[15:0]), 'h2000);
    chk("R2 next_pc", int'(next_pc[15:0]), 'h2004);
    chk("R2 other thread", st(1), 0);
    tick();
    chk("R7 squash to run", st(0), 0);
  endtask

  task automatic t_rob();
    rob_squashing = 2'b01; tick();
    chk("R4 rob first", st(0), 2);
    tick();
    chk("R4 rob held", st(0), 2);
    idle(); tick();
    chk("R7 rob release", st(0), 0);
  endtask

  task automatic t_decode();
    dec_squash = 2'b01; dec_target[15:0] = 16'h3000; tick();
    chk("R5 decode redirect state", st(0), 2);
    chk("R5 decode redirect pc", int'(pc[15:0]), 'h3000);
    dec_target[15:0] = 16'h3333; tick(); idle();
    chk("R5 no redirect while squashing", int'(pc[15:0]), 'h3000);
    chk("R7 falls through to run", st(0), 0);
  endtask

  task automatic t_stall();
    stall_set[1] = 1; tick(); idle();
    chk("R6 rename stall", st(0), 3);
    tick();
    chk("R1 stall sticky", st(0), 3);
    stall_clr[1] = 1; tick(); idle();
    chk("R1 unblock", st(0), 0);
    stall_set[7] = 1; tick(); idle();
    chk("R1 commit flag t1", st(1), 3);
    chk("R1 t0 unaffected", st(0), 0);
    stall_clr[7] = 1; tick(); idle(); tick();
    chk("R7 t1 recovers", st(1), 0);
    ctx_switch = 1; tick();
    chk("R6 ctx switch", st(0), 3);
    idle(); tick();
    chk("R7 ctx release", st(0), 0);
  endtask

  task automatic t_miss_stall();
    miss_issue = 2'b01; miss_tag[2:0] = 3'd5; tick(); idle();
    chk("R8 issue", st(0), 4);
    stall_set[0] = 1; tick(); idle();
    chk("R6 wait not blocked", st(0), 4);
    resp_valid = 1; resp_tid = 0; resp_tag = 3'd3; tick(); idle();
    chk("R9 wrong tag", st(0), 4);
    resp_valid = 1; resp_tid = 1; resp_tag = 3'd5; tick(); idle();
    chk("R9 wrong thread", st(0), 4);
    resp_valid = 1; resp_tid = 0; resp_tag = 3'd5; tick(); idle();
    chk("R10 accepted with stall", st(0), 3);
    stall_clr[0] = 1; tick(); idle();
    chk("R7 unstall", st(0), 0);
  endtask

  task automatic t_miss_active();
    miss_issue = 2'b11; miss_tag = {3'd6, 3'd1}; tick(); idle();
    chk("R8 both wait", st(0) * 8 + st(1), 4 * 8 + 4);
    chk("R11 inactive all waiting", int'(stage_active), 0);
    resp_valid = 1; resp_tid = 0; resp_tag = 3'd1; tick(); idle();
    chk("R10 mem done", st(0), 5);
    chk("R11 active on done", int'(stage_active), 1);
    tick();
    chk("R10 done to run", st(0), 0);
    cmt_squash = 2'b10; cmt_target[31:16] = 16'h4000; tick(); idle();
    chk("R3 squash in wait", st(1), 2);
    tick();
    miss_issue = 2'b10; miss_tag[5:3] = 3'd7; tick(); idle();
    chk("R8 reissue", st(1), 4);
    resp_valid = 1; resp_tid = 1; resp_tag = 3'd6; tick(); idle();
    chk("R3 stale tag dropped", st(1), 4);
    resp_valid = 1; resp_tid = 1; resp_tag = 3'd7; tick(); idle();
    chk("R10 fresh tag", st(1), 5);
    tick();
  endtask

  task automatic t_mask();
    thread_active = 2'b01; miss_issue = 2'b01; miss_tag[2:0] = 3'd2; tick(); idle();
    chk("R11 masked thread ignored", int'(stage_active), 0);
    chk("R11 t1 running", st(1), 0);
    thread_active = 2'b11; resp_valid = 1; resp_tid = 0; resp_tag = 3'd2; tick(); idle(); tick();
  endtask

  task automatic t_proto();
    stall_set[2] = 1; stall_clr[2] = 1; tick(); idle();
    chk("R12 error flag", int'(proto_err), 1);
    chk("R12 set wins", st(0), 3);
    tick();
    chk("R12 error one cycle", int'(proto_err), 0);
    stall_clr[2] = 1; tick(); idle(); tick();
    chk("R7 after proto", st(0), 0);
  endtask

  initial begin
    idle(); thread_active = 2'b11;
    t_reset();
    t_commit();
    t_rob();
    t_decode();
    t_stall();
    t_miss_stall();
    t_miss_active();
    t_mask();
    t_proto();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule